// File: doc/BRIEF.md
# DMA Transfer Counter with Repeat Reload

This block is the counting and addressing core of a single DMA channel. Each accepted transfer strobe moves a memory address register by a programmable step and decrements a transfer count. The count has two behaviours, chosen by `repeat_mode`. In sequential (or idle) operation the whole count register is one down-counter, and the channel disables itself once the last transfer is done. In repeat operation only the lower half counts, and the upper half holds a reload value. On each wrap the lower half reloads, the address register returns to the value software last wrote, and the channel stays enabled.

Software programs the address, the count and the enable through single-cycle write strobes. Bus arbitration, data movement and interrupt generation sit around the block and are not part of it. `end_pulse` marks each completed run (sequential) or each completed cycle (repeat), so neighbouring logic can raise an interrupt or start a new block.

Top module: `dma_count_engine`

## Requirements
- R1: In sequential mode (`repeat_mode`=0), every accepted transfer decrements the full CNT_W-bit count by one. A count of zero counts as 2^CNT_W transfers.
- R2: In sequential mode, a transfer that brings the count to zero clears `chan_en`.
- R3: In repeat mode (`repeat_mode`=1), only the lower CNT_W/2 bits count. The upper CNT_W/2 bits stay unchanged on a transfer.
- R4: In repeat mode, a transfer that would take the lower half to zero instead loads the lower half with the upper half.
- R5: On that repeat reload, `cur_addr` becomes the saved start address. It does not step.
- R6: In repeat mode, `chan_en` is never cleared by counting.
- R7: Each write to the address (`addr_wr`) sets both `cur_addr` and the saved start address, so the next restore uses the latest write.
- R8: On an accepted transfer without reload, the address changes by `step_dir` as follows: 2'b01 adds the step, 2'b10 subtracts the step, and 2'b00 or 2'b11 holds the address. The step is 2 when `step_wide`=1 and 1 when `step_wide`=0.
- R9: `end_pulse` is high for one cycle after a sequential transfer that reaches zero and after each repeat reload. It is low otherwise.
- R10: A transfer strobe while `chan_en` is low changes neither the count nor the address.
- R11: After reset, `cur_addr`, `cur_count`, `chan_en` and `end_pulse` are all zero.
- R12: Register writes take priority over the transfer update of the same register in the same cycle. `en_clr` takes priority over `en_set`, and `en_set` takes priority over the automatic clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer | input | 1 | One completed transfer this cycle |
| repeat_mode | input | 1 | 1 = repeat reload, 0 = sequential/idle |
| step_dir | input | 2 | 01 up, 10 down, 00/11 fixed |
| step_wide | input | 1 | 1 = step of 2 (word), 0 = step of 1 (byte) |
| addr_wr | input | 1 | Write the address and the saved start address |
| addr_wdata | input | ADDR_W | Address write data |
| cnt_wr | input | 1 | Write the count register |
| cnt_wdata | input | CNT_W | Count write data (repeat: upper half = reload, lower half = counter) |
| en_set | input | 1 | Set channel enable |
| en_clr | input | 1 | Clear channel enable |
| cur_addr | output | ADDR_W | Current memory address |
| cur_count | output | CNT_W | Current count register |
| chan_en | output | 1 | Channel enable |
| end_pulse | output | 1 | One-cycle end / wrap marker |

## Verification
Every result is registered once. An input sampled at a rising edge therefore shows on `cur_addr`, `cur_count`, `chan_en` and `end_pulse` straight after that edge, and stays there until the next edge. The bench drives stimulus on the falling edge. It advances its own model of the requirements just after the rising edge that samples the stimulus, and compares all four outputs on the following falling edge. Each check thus lands exactly one edge after its cause and before any new stimulus.

// File: rtl/dmace_pkg.sv
package dmace_pkg;

    typedef enum logic [1:0] {
        DIR_FIXED  = 2'b00,
        DIR_UP     = 2'b01,
        DIR_DOWN   = 2'b10,
        DIR_FIXED2 = 2'b11
    } dir_e;

endpackage

// File: rtl/dmace_count_unit.sv
module dmace_count_unit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer,
    input  logic             repeat_mode,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             en_set,
    input  logic             en_clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             en_q,
    output logic             end_q,
    output logic             accept,
    output logic             wrap
);
    localparam int HALF = CNT_W / 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             en;
        logic             fin;
    } cstate_t;

    cstate_t          st_d, st_q;
    logic [CNT_W-1:0] full_next;
    logic [HALF-1:0]  lo_next;
    logic [HALF-1:0]  hi_hold;
    logic             seq_done;

    always_comb begin
        accept    = xfer && st_q.en;
        full_next = st_q.cnt - CNT_W'(1);
        lo_next   = st_q.cnt[HALF-1:0] - HALF'(1);
        hi_hold   = st_q.cnt[CNT_W-1:HALF];
        wrap      = accept && repeat_mode && (lo_next == '0);
        seq_done  = accept && !repeat_mode && (full_next == '0);

        st_d     = st_q;
        st_d.fin = wrap || seq_done;

        if (cnt_wr) begin
            st_d.cnt = cnt_wdata;
        end else if (accept) begin
            if (repeat_mode) begin
                st_d.cnt = wrap ? {hi_hold, hi_hold} : {hi_hold, lo_next};
            end else begin
                st_d.cnt = full_next;
            end
        end

        if (en_clr) begin
            st_d.en = 1'b0;
        end else if (en_set) begin
            st_d.en = 1'b1;
        end else if (seq_done) begin
            st_d.en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.cnt;
    assign en_q  = st_q.en;
    assign end_q = st_q.fin;

    p_dec_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && en_q && !repeat_mode && !cnt_wr) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    p_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && en_q && !repeat_mode && cnt_q == CNT_W'(1) && !en_set) |=> !en_q);

    p_hi_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && en_q && repeat_mode && !cnt_wr) |=>
        (cnt_q[CNT_W-1:HALF] == $past(cnt_q[CNT_W-1:HALF])));

    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && en_q && repeat_mode && cnt_q[HALF-1:0] == HALF'(1) && !cnt_wr) |=>
        (cnt_q[HALF-1:0] == $past(cnt_q[CNT_W-1:HALF])));

    p_keep_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && repeat_mode && !en_clr) |=> en_q);

    p_end_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        end_q |-> ($past(xfer) && $past(en_q)));

    p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !en_q && !cnt_wr) |=> ($stable(cnt_q) && !end_q));

endmodule

// File: rtl/dmace_addr_unit.sv
module dmace_addr_unit #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              restore,
    input  logic [1:0]        step_dir,
    input  logic              step_wide,
    input  logic              addr_wr,
    input  logic [ADDR_W-1:0] addr_wdata,
    output logic [ADDR_W-1:0] addr_q
);
    import dmace_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] shadow;
    } astate_t;

    astate_t           st_d, st_q;
    logic [ADDR_W-1:0] delta;
    dir_e              dir;

    always_comb begin
        dir   = dir_e'(step_dir);
        delta = step_wide ? ADDR_W'(2) : ADDR_W'(1);
        st_d  = st_q;
        if (addr_wr) begin
            st_d.addr   = addr_wdata;
            st_d.shadow = addr_wdata;
        end else if (restore) begin
            st_d.addr = st_q.shadow;
        end else if (advance) begin
            case (dir)
                DIR_UP:   st_d.addr = st_q.addr + delta;
                DIR_DOWN: st_d.addr = st_q.addr - delta;
                default:  st_d.addr = st_q.addr;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_q = st_q.addr;

    p_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (restore && !addr_wr) |=> (addr_q == $past(st_q.shadow)));

    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wr |=> (st_q.shadow == $past(addr_wdata) && addr_q == $past(addr_wdata)));

    p_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !restore && !addr_wr && (step_dir == 2'b00 || step_dir == 2'b11))
        |=> $stable(addr_q));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !restore && !addr_wr) |=> $stable(addr_q));

endmodule

// File: rtl/dma_count_engine.sv
module dma_count_engine #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer,
    input  logic              repeat_mode,
    input  logic [1:0]        step_dir,
    input  logic              step_wide,
    input  logic              addr_wr,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              en_set,
    input  logic              en_clr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_count,
    output logic              chan_en,
    output logic              end_pulse
);
    logic accept;
    logic wrap;

    dmace_count_unit #(.CNT_W(CNT_W)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .xfer        (xfer),
        .repeat_mode (repeat_mode),
        .cnt_wr      (cnt_wr),
        .cnt_wdata   (cnt_wdata),
        .en_set      (en_set),
        .en_clr      (en_clr),
        .cnt_q       (cur_count),
        .en_q        (chan_en),
        .end_q       (end_pulse),
        .accept      (accept),
        .wrap        (wrap)
    );

    dmace_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (accept),
        .restore    (wrap),
        .step_dir   (step_dir),
        .step_wide  (step_wide),
        .addr_wr    (addr_wr),
        .addr_wdata (addr_wdata),
        .addr_q     (cur_addr)
    );

    p_end_means_wrap_or_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !repeat_mode && cur_count == CNT_W'(1)) |=> end_pulse);

endmodule

// File: tb/dma_count_engine_test.sv
module dma_count_engine_test;
    localparam int AW = 24;
    localparam int CW = 16;
    localparam int HW = CW / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xfer = 1'b0, repeat_mode = 1'b0, step_wide = 1'b0;
    logic [1:0]    step_dir = 2'b00;
    logic          addr_wr = 1'b0, cnt_wr = 1'b0, en_set = 1'b0, en_clr = 1'b0;
    logic [AW-1:0] addr_wdata = '0;
    logic [CW-1:0] cnt_wdata = '0;
    logic [AW-1:0] cur_addr;
    logic [CW-1:0] cur_count;
    logic          chan_en, end_pulse;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [AW-1:0] m_addr = '0, m_shadow = '0;
    logic [CW-1:0] m_cnt = '0;
    logic          m_en = 1'b0, m_end = 1'b0;
    string         t_addr, t_cnt, t_en;

    always #2.5 clk = ~clk;

    dma_count_engine #(.ADDR_W(AW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .xfer(xfer), .repeat_mode(repeat_mode),
        .step_dir(step_dir), .step_wide(step_wide), .addr_wr(addr_wr),
        .addr_wdata(addr_wdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .en_set(en_set), .en_clr(en_clr), .cur_addr(cur_addr),
        .cur_count(cur_count), .chan_en(chan_en), .end_pulse(end_pulse)
    );

    function automatic logic [AW-1:0] f_step(logic [AW-1:0] a, logic [1:0] d, logic w);
        logic [AW-1:0] s;
        s = w ? AW'(2) : AW'(1);
        if (d == 2'b01) return a + s;
        if (d == 2'b10) return a - s;
        return a;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h time=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_update();
        logic acc, wr, fin;
        logic [HW-1:0] lo, hi;
        acc = xfer && m_en;
        lo  = m_cnt[HW-1:0] - HW'(1);
        hi  = m_cnt[CW-1:HW];
        wr  = acc && repeat_mode && (lo == '0);
        fin = acc && !repeat_mode && (m_cnt - CW'(1) == '0);
        t_addr = addr_wr ? "R7" : wr ? "R5" : acc ? "R8" : xfer ? "R10" : "R8";
        t_cnt  = cnt_wr ? "R12" : wr ? "R4" : (acc && repeat_mode) ? "R3" :
                 acc ? "R1" : xfer ? "R10" : "R1";
        t_en   = (en_clr || en_set) ? "R12" : fin ? "R2" : repeat_mode ? "R6" : "R2";
        if (addr_wr) begin
            m_addr = addr_wdata; m_shadow = addr_wdata;
        end else if (wr) m_addr = m_shadow;
        else if (acc) m_addr = f_step(m_addr, step_dir, step_wide);
        if (cnt_wr) m_cnt = cnt_wdata;
        else if (acc) m_cnt = repeat_mode ? (wr ? {hi, hi} : {hi, lo}) : m_cnt - CW'(1);
        if (en_clr) m_en = 1'b0;
        else if (en_set) m_en = 1'b1;
        else if (fin) m_en = 1'b0;
        m_end = wr || fin;
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        check(t_addr, 32'(cur_addr), 32'(m_addr));
        check(t_cnt, 32'(cur_count), 32'(m_cnt));
        check(t_en, 32'(chan_en), 32'(m_en));
        check("R9", 32'(end_pulse), 32'(m_end));
        xfer = 0; addr_wr = 0; cnt_wr = 0; en_set = 0; en_clr = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
            finish_run();
        end
    end

    initial begin
        int r;
        void'($urandom(32'd1234));
        #1;
        check("R11", 32'(cur_addr), 0);
        check("R11", 32'(cur_count), 0);
        check("R11", 32'(chan_en), 0);
        check("R11", 32'(end_pulse), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: disabled strobes ignored
        step_dir = 2'b01;
        addr_wr = 1; addr_wdata = 24'h100; cnt_wr = 1; cnt_wdata = 16'd3; tick();
        xfer = 1; tick();
        xfer = 1; tick();

        // R1/R2/R9: sequential run of 3, word step up
        step_wide = 1; en_set = 1; tick();
        for (int i = 0; i < 4; i++) begin xfer = 1; tick(); end

        // R3/R4/R5/R6/R9: repeat, reload 2, byte step down
        repeat_mode = 1; step_wide = 0; step_dir = 2'b10;
        addr_wr = 1; addr_wdata = 24'h200; cnt_wr = 1; cnt_wdata = 16'h0202; en_set = 1; tick();
        for (int i = 0; i < 6; i++) begin xfer = 1; tick(); end

        // R7: new address write updates the restore point
        addr_wr = 1; addr_wdata = 24'h3F0; tick();
        for (int i = 0; i < 3; i++) begin xfer = 1; tick(); end

        // R8: fixed codes 00 and 11
        step_dir = 2'b00; xfer = 1; tick();
        step_dir = 2'b11; step_wide = 1; xfer = 1; tick();

        // R12: clear beats set
        en_set = 1; en_clr = 1; tick();
        xfer = 1; tick();

        // random phase
        for (int i = 0; i < 3000; i++) begin
            r = int'($urandom % 100);
            xfer      = (r < 60);
            step_dir  = 2'($urandom);
            step_wide = 1'($urandom);
            if ($urandom % 100 < 3) begin addr_wr = 1; addr_wdata = 24'($urandom); end
            if ($urandom % 100 < 4) begin
                cnt_wr = 1;
                cnt_wdata = {8'($urandom % 4), 8'($urandom % 5)};
                repeat_mode = 1'($urandom);
            end
            if (!m_en && $urandom % 100 < 10) en_set = 1;
            if ($urandom % 100 < 2) en_clr = 1;
            tick();
        end
        finish_run();
    end
endmodule